// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets processors on one chip post short messages to each other through a small memory-mapped register space. It holds a parameterised number of channels, 32 by default. Each channel carries one eight-word message in one direction at a time. A sender first unlocks the block with a key. It then claims an idle channel by writing its own one-hot acknowledge-vector bit and reads that bit back to confirm ownership. Next it unmasks and selects a destination vector, chooses the acknowledge mode, fills the message words, and starts the transfer by writing its source bit to the send register.

The send sets the destination status bits, and these drive one interrupt output per vector through a per-channel mask. In automatic mode the channel moves from busy to acknowledged one cycle later with no help from the receiver. In manual mode it waits until the receiver writes the destination-clear register. The owner releases the channel by masking every vector and writing its source bit again. The bus is a single-cycle write strobe with a combinational read path.

Top module: `ipc_mailbox`

## Requirements
- R1: The global lock sits at byte address 0xA00 and is engaged after reset. Reading it returns 1 while locked and 0 when unlocked. Writing 0x1ACCE551 unlocks the block, and writing any other value engages the lock again.
- R2: While the lock is engaged, bus writes to any channel register change nothing. Reads still return the stored values.
- R3: Channel c occupies byte addresses c*0x40 to c*0x40+0x3F. Word offsets are: source 0x00, destination 0x04, destination-clear 0x08, destination-status 0x0C, mode/state 0x10, mask 0x14, interrupt-clear 0x18, send 0x1C, data 0x20 to 0x3C. Any other address reads as zero, and writes to it are ignored.
- R4: A write of a one-hot value to the source register of an idle channel makes that value the owner, and it reads back from the source register. A value that is not one-hot, or any claim on a channel that is not idle, leaves the source register unchanged.
- R5: The mode/state register reads bit 4 = 1 when the channel is idle, bit 7 = 1 when it is acknowledged, and bit 0 = the acknowledge-mode bit (1 = automatic), as last written. All other bits read 0.
- R6: The eight data words can be written and read back at offsets 0x20 to 0x3C, one word per 4 bytes.
- R7: A write to the send register of an owned channel, with a value equal to the owner, ORs the destination register into the destination status and makes the channel busy (bits 4 and 7 both read 0). Any other send value has no effect.
- R8: In automatic mode, a busy channel becomes acknowledged on the next clock edge.
- R9: In manual mode, a busy channel stays busy until its destination-clear register is written, and then it becomes acknowledged.
- R10: Interrupt output k is the OR over all channels of (status bit k AND NOT mask bit k). Every mask resets to all ones.
- R11: Writing ones to destination-clear or to interrupt-clear clears the matching destination-status bits.
- R12: When the mask is all ones, writing the owner's bit to the source register of a non-idle channel returns the channel to idle and clears its owner and status. With any mask bit clear, that write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_o | output | 32 | One interrupt line per vector |

## Verification
The main send flow is run first in automatic mode on one channel. It reads the mode register in the cycle right after the send and again one cycle later, which separates the busy state from the self-acknowledged state. The flow is then repeated in manual mode, where the channel must stay busy over several idle cycles until the receiver clears it. Two channels that post to different vectors at the same time, one of them with a partly masked destination, show that the interrupt lines merge across channels and that the mask applies per bit. Claims with a non-one-hot value, claims on an owned channel, sends with a wrong source bit, releases while unmasked, and writes while relocked each confirm that the guarding condition, not just the address, decides whether state changes.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_OWNED = 2'd1,
    CH_BUSY  = 2'd2,
    CH_ACKED = 2'd3
  } ch_state_e;

  // word index inside a channel window (byte offset / 4)
  localparam int unsigned W_SRC   = 0;
  localparam int unsigned W_DST   = 1;
  localparam int unsigned W_DCLR  = 2;
  localparam int unsigned W_DSTAT = 3;
  localparam int unsigned W_MODE  = 4;
  localparam int unsigned W_MASK  = 5;
  localparam int unsigned W_ICLR  = 6;
  localparam int unsigned W_SEND  = 7;
  localparam int unsigned W_DATA0 = 8;

  localparam int unsigned MODE_AUTO_BIT = 0;
  localparam int unsigned MODE_IDLE_BIT = 4;
  localparam int unsigned MODE_ACK_BIT  = 7;

endpackage

// File: rtl/ipc_mbox_dec.sv
module ipc_mbox_dec #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_CH    = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned FIELD_W  = ADDR_W - 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   ch_idx,
  output logic [3:0]        widx,
  output logic              ch_hit,
  output logic              lock_hit
);

  localparam logic [FIELD_W-1:0] NUM_CH_F = FIELD_W'(NUM_CH);

  logic [FIELD_W-1:0] field;
  logic               unused_low;

  assign field      = addr[ADDR_W-1:6];
  assign ch_idx     = field[CH_W-1:0];
  assign widx       = addr[5:2];
  assign ch_hit     = (field < NUM_CH_F);
  assign lock_hit   = (addr[ADDR_W-1:2] == LOCK_ADDR[ADDR_W-1:2]);
  assign unused_low = ^addr[1:0];

endmodule

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MSG_WORDS = 8,
  localparam int unsigned DW_IDX   = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] irq_vec,
  output logic [1:0]        state_o,
  output logic [DATA_W-1:0] src_o,
  output logic              auto_o
);

  localparam logic [3:0] MSG_WORDS_4 = 4'(MSG_WORDS);

  ch_state_e                        st_q, st_n;
  logic [DATA_W-1:0]                src_q, src_n;
  logic [DATA_W-1:0]                dst_q, dst_n;
  logic [DATA_W-1:0]                dstat_q, dstat_n;
  logic [DATA_W-1:0]                mask_q, mask_n;
  logic                             auto_q, auto_n;
  logic [MSG_WORDS-1:0][DATA_W-1:0] data_q, data_n;

  logic [3:0] woff, roff;
  logic       w_is_data, r_is_data, w_onehot;

  assign woff      = widx - 4'(W_DATA0);
  assign roff      = ridx - 4'(W_DATA0);
  assign w_is_data = widx[3] && (woff < MSG_WORDS_4);
  assign r_is_data = ridx[3] && (roff < MSG_WORDS_4);
  assign w_onehot  = (wdata != '0) && ((wdata & (wdata - 1'b1)) == '0);

  // next-state
  always_comb begin
    st_n    = st_q;
    src_n   = src_q;
    dst_n   = dst_q;
    dstat_n = dstat_q;
    mask_n  = mask_q;
    auto_n  = auto_q;
    data_n  = data_q;
    if (st_q == CH_BUSY && auto_q) st_n = CH_ACKED;
    if (wr_en) begin
      case (widx)
        4'(W_SRC): begin
          if (st_q == CH_IDLE) begin
            if (w_onehot) begin
              src_n = wdata;
              st_n  = CH_OWNED;
            end
          end else if (wdata == src_q && (&mask_q)) begin
            src_n   = '0;
            dstat_n = '0;
            st_n    = CH_IDLE;
          end
        end
        4'(W_DST):  dst_n = wdata;
        4'(W_DCLR): begin
          dstat_n = dstat_q & ~wdata;
          if (st_q == CH_BUSY && !auto_q) st_n = CH_ACKED;
        end
        4'(W_MODE): auto_n = wdata[MODE_AUTO_BIT];
        4'(W_MASK): mask_n = wdata;
        4'(W_ICLR): dstat_n = dstat_q & ~wdata;
        4'(W_SEND): begin
          if (st_q == CH_OWNED && wdata == src_q) begin
            dstat_n = dstat_q | dst_q;
            st_n    = CH_BUSY;
          end
        end
        default: begin
          if (w_is_data) data_n[woff[DW_IDX-1:0]] = wdata;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      dstat_q <= '0;
      mask_q  <= '1;
      auto_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      dstat_q <= dstat_n;
      mask_q  <= mask_n;
      auto_q  <= auto_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_en && w_is_data) begin
      data_q <= data_n;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (ridx)
      4'(W_SRC):   rdata = src_q;
      4'(W_DST):   rdata = dst_q;
      4'(W_DSTAT): rdata = dstat_q;
      4'(W_MODE): begin
        rdata[MODE_AUTO_BIT] = auto_q;
        rdata[MODE_IDLE_BIT] = (st_q == CH_IDLE);
        rdata[MODE_ACK_BIT]  = (st_q == CH_ACKED);
      end
      4'(W_MASK):  rdata = mask_q;
      default: begin
        if (r_is_data) rdata = data_q[roff[DW_IDX-1:0]];
      end
    endcase
  end

  assign irq_vec = dstat_q & ~mask_q;
  assign state_o = st_q;
  assign src_o   = src_q;
  assign auto_o  = auto_q;

endmodule

// File: rtl/ipc_mbox_irq_or.sv
module ipc_mbox_irq_or #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned W      = 32
) (
  input  logic [NUM_CH-1:0][W-1:0] vec_i,
  output logic [W-1:0]             irq_o
);

  always_comb begin
    irq_o = '0;
    for (int c = 0; c < NUM_CH; c++) irq_o = irq_o | vec_i[c];
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] irq_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [CH_W-1:0] ch_idx;
  logic [3:0]      widx;
  logic            ch_hit, lock_hit;

  ipc_mbox_dec #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .LOCK_ADDR(LOCK_ADDR)
  ) u_dec (
    .addr(addr), .ch_idx(ch_idx), .widx(widx),
    .ch_hit(ch_hit), .lock_hit(lock_hit)
  );

  // global lock
  logic lock_q, lock_n;

  always_comb begin
    lock_n = lock_q;
    if (wr_en && lock_hit) lock_n = (wdata != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lock_q <= 1'b1;
    else         lock_q <= lock_n;
  end

  // channels
  logic [NUM_CH-1:0]             chan_wr;
  logic [NUM_CH-1:0][DATA_W-1:0] chan_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] chan_irq;
  logic [NUM_CH-1:0][1:0]        st_all;
  logic [NUM_CH-1:0][DATA_W-1:0] src_all;
  logic [NUM_CH-1:0]             auto_all;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign chan_wr[c] = wr_en && ch_hit && !lock_q && (ch_idx == CH_W'(c));

    ipc_mbox_chan #(
      .DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)
    ) u_chan (
      .clk(clk), .rst_n(srst_n), .wr_en(chan_wr[c]), .widx(widx),
      .wdata(wdata), .ridx(widx), .rdata(chan_rd[c]),
      .irq_vec(chan_irq[c]), .state_o(st_all[c]),
      .src_o(src_all[c]), .auto_o(auto_all[c])
    );
  end

  ipc_mbox_irq_or #(.NUM_CH(NUM_CH), .W(DATA_W)) u_irq (
    .vec_i(chan_irq), .irq_o(irq_o)
  );

  always_comb begin
    rdata = '0;
    if (lock_hit)    rdata = {{(DATA_W-1){1'b0}}, lock_q};
    else if (ch_hit) rdata = chan_rd[ch_idx];
  end

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input logic                        clk,
  input logic                        srst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [DATA_W-1:0]           irq_o,
  input logic                        lock_q,
  input logic [NUM_CH-1:0][1:0]      st_all,
  input logic [NUM_CH-1:0][DATA_W-1:0] src_all,
  input logic [NUM_CH-1:0]           auto_all
);

  logic [ADDR_W-7:0] fld;
  logic [3:0]        wix;
  logic              at_lock;

  assign fld     = addr[ADDR_W-1:6];
  assign wix     = addr[5:2];
  assign at_lock = (addr[ADDR_W-1:2] == LOCK_ADDR[ADDR_W-1:2]);

  // R1: writing the key opens the lock on the next edge
  p_key_unlocks_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && at_lock && wdata == UNLOCK_KEY) |=> !lock_q);

  // R2: owners cannot change while locked
  p_locked_frozen_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (lock_q && wr_en && !at_lock) |=> $stable(src_all));

  // R10: a new interrupt line can only rise after a bus write
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ((irq_o & ~$past(irq_o)) != '0) |-> $past(wr_en));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic wr_c;
    assign wr_c = wr_en && !lock_q && (fld == (ADDR_W-6)'(c));

    // R4: a foreign claim on a non-idle channel keeps the owner
    p_claim_guard_r4: assert property (@(posedge clk) disable iff (!srst_n)
      (wr_c && wix == 4'd0 && st_all[c] != 2'd0 && wdata != src_all[c])
      |=> $stable(src_all[c]));

    // R8: automatic acknowledge one edge after busy
    p_auto_ack_r8: assert property (@(posedge clk) disable iff (!srst_n)
      (st_all[c] == 2'd2 && auto_all[c] && !(wr_c && wix == 4'd0))
      |=> st_all[c] == 2'd3);

    // R9: manual channel holds busy until cleared
    p_manual_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
      (st_all[c] == 2'd2 && !auto_all[c] && !(wr_c && (wix == 4'd0 || wix == 4'd2)))
      |=> st_all[c] == 2'd2);
  end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .LOCK_ADDR(LOCK_ADDR), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_o(irq_o), .lock_q(lock_q), .st_all(st_all), .src_all(src_all),
  .auto_all(auto_all)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;

  logic        clk, rst_n, wr_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  ipc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {op[1:0], req[3:0], addr[11:0], data[31:0]}; op 0 write, 1 read, 2 irq
  localparam logic [49:0] VEC [NV] = '{
    {2'd1, 4'd1,  12'hA00, 32'h0000_0001},  // R1 locked after reset
    {2'd2, 4'd10, 12'h000, 32'h0000_0000},  // R10 no interrupt
    {2'd0, 4'd2,  12'h0C0, 32'h0000_0020},  // R2 claim while locked
    {2'd1, 4'd2,  12'h0C0, 32'h0000_0000},
    {2'd0, 4'd1,  12'hA00, 32'h1ACC_E551},  // R1 unlock
    {2'd1, 4'd1,  12'hA00, 32'h0000_0000},
    {2'd1, 4'd5,  12'h0D0, 32'h0000_0010},  // R5 idle
    {2'd0, 4'd4,  12'h0C0, 32'h0000_0020},  // R4 claim
    {2'd1, 4'd4,  12'h0C0, 32'h0000_0020},
    {2'd1, 4'd5,  12'h0D0, 32'h0000_0000},
    {2'd0, 4'd10, 12'h0D4, 32'hFFFF_FDFF},
    {2'd0, 4'd7,  12'h0C4, 32'h0000_0200},
    {2'd0, 4'd5,  12'h0D0, 32'h0000_0001},
    {2'd0, 4'd6,  12'h0E0, 32'h1111_1111},  // R6 data
    {2'd0, 4'd6,  12'h0E4, 32'h2222_2222},
    {2'd0, 4'd6,  12'h0E8, 32'h3333_3333},
    {2'd0, 4'd6,  12'h0EC, 32'h4444_4444},
    {2'd0, 4'd6,  12'h0F0, 32'h5555_5555},
    {2'd0, 4'd6,  12'h0F4, 32'h6666_6666},
    {2'd0, 4'd6,  12'h0F8, 32'h7777_7777},
    {2'd0, 4'd6,  12'h0FC, 32'h8888_8888},
    {2'd0, 4'd7,  12'h0DC, 32'h0000_0020},  // R7 send
    {2'd1, 4'd8,  12'h0D0, 32'h0000_0001},  // R8 busy
    {2'd1, 4'd8,  12'h0D0, 32'h0000_0081},  // R8 acked
    {2'd2, 4'd10, 12'h000, 32'h0000_0200},
    {2'd1, 4'd7,  12'h0CC, 32'h0000_0200},
    {2'd1, 4'd6,  12'h0E0, 32'h1111_1111},
    {2'd1, 4'd6,  12'h0F0, 32'h5555_5555},
    {2'd1, 4'd6,  12'h0FC, 32'h8888_8888},
    {2'd0, 4'd12, 12'h0D4, 32'hFFFF_FFFF},  // R12 mask all
    {2'd2, 4'd10, 12'h000, 32'h0000_0000},
    {2'd0, 4'd12, 12'h0C0, 32'h0000_0020},  // R12 release
    {2'd1, 4'd12, 12'h0D0, 32'h0000_0011},
    {2'd1, 4'd12, 12'h0C0, 32'h0000_0000},
    {2'd1, 4'd12, 12'h0CC, 32'h0000_0000},
    {2'd1, 4'd3,  12'h800, 32'h0000_0000}   // R3 out of range
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input string what, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1 chk(what, rdata, exp);
    @(negedge clk);
  endtask

  task automatic irq_chk(input string what, input logic [31:0] exp);
    #1 chk(what, irq_o, exp);
    @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d step %0d", e[47:44], i);
      case (e[49:48])
        2'd0: bus_wr(e[43:32], e[31:0]);
        2'd1: bus_rd(tag, e[43:32], e[31:0]);
        default: irq_chk(tag, e[31:0]);
      endcase
    end

    // R4 claim on owned channel and non-one-hot claim
    bus_wr(12'h140, 32'h1);
    bus_wr(12'h140, 32'h2);
    bus_rd("R4 busy claim", 12'h140, 32'h1);
    bus_wr(12'h180, 32'h3);
    bus_rd("R4 non-onehot claim", 12'h180, 32'h0);
    bus_rd("R4 still idle", 12'h190, 32'h10);

    // R9 manual acknowledge on channel 5
    bus_wr(12'h154, 32'hFFFF_FFFE);
    bus_wr(12'h144, 32'h1);
    bus_wr(12'h150, 32'h0);
    bus_wr(12'h15C, 32'h1);
    bus_rd("R9 busy after send", 12'h150, 32'h0);
    repeat (5) @(negedge clk);
    bus_rd("R9 still busy", 12'h150, 32'h0);
    irq_chk("R10 manual irq", 32'h1);
    bus_wr(12'h148, 32'h1);
    bus_rd("R9 acked after clear", 12'h150, 32'h80);
    irq_chk("R11 cleared irq", 32'h0);
    bus_rd("R11 status cleared", 12'h14C, 32'h0);

    // R7 wrong source bit on channel 6
    bus_wr(12'h180, 32'h1);
    bus_wr(12'h194, 32'hFFFF_FFFD);
    bus_wr(12'h184, 32'h2);
    bus_wr(12'h19C, 32'h4);
    irq_chk("R7 wrong send no irq", 32'h0);
    bus_rd("R7 still owned", 12'h190, 32'h0);
    bus_rd("R7 status untouched", 12'h18C, 32'h0);

    // R12 release refused while unmasked
    bus_wr(12'h180, 32'h1);
    bus_rd("R12 release refused", 12'h180, 32'h1);

    // R10 / R11 two channels merged, partial mask, interrupt-clear
    bus_wr(12'h1C0, 32'h4);
    bus_wr(12'h1D4, 32'hFFFF_FFF7);
    bus_wr(12'h1C4, 32'h18);
    bus_wr(12'h1D0, 32'h1);
    bus_wr(12'h1DC, 32'h4);
    irq_chk("R10 partial mask", 32'h8);
    bus_wr(12'h19C, 32'h1);
    irq_chk("R10 merged channels", 32'hA);
    bus_rd("R7 status both bits", 12'h1CC, 32'h18);
    bus_wr(12'h1D8, 32'h8);
    irq_chk("R11 iclr", 32'h2);
    bus_rd("R11 iclr status", 12'h1CC, 32'h10);
    bus_wr(12'h188, 32'h2);
    irq_chk("R11 dclr", 32'h0);
    bus_rd("R9 ch6 acked", 12'h190, 32'h80);

    // R1 / R2 relock
    bus_wr(12'hA00, 32'hDEAD_BEEF);
    bus_rd("R1 relocked", 12'hA00, 32'h1);
    bus_wr(12'h200, 32'h1);
    bus_rd("R2 claim ignored", 12'h200, 32'h0);
    bus_wr(12'h1D4, 32'h0);
    irq_chk("R2 mask write ignored", 32'h0);
    bus_rd("R2 read while locked", 12'h1D4, 32'hFFFF_FFF7);

    // R3 address map
    bus_rd("R3 above lock", 12'hA04, 32'h0);
    bus_rd("R3 gap", 12'h9FC, 32'h0);
    bus_rd("R3 ch3 word1", 12'h0E4, 32'h2222_2222);

    // R1 / R5 / R10 reset in mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd("R1 reset lock", 12'hA00, 32'h1);
    bus_rd("R5 reset idle", 12'h0D0, 32'h10);
    bus_rd("R10 reset mask", 12'h0D4, 32'hFFFF_FFFF);
    irq_chk("R10 reset irq", 32'h0);
    bus_rd("R6 reset data", 12'h0E0, 32'h0);

    report();
  end

endmodule